// File: doc/BRIEF.md
# DMA Event Interrupt Aggregator

This block collects completion events from four DMA channels of a crypto data-feed unit and turns them into one interrupt request line. Each channel delivers a single-cycle event pulse, which the block latches into a sticky status bit. An enable mask decides which latched events may raise the interrupt. Software reaches the status, the mask and the masked pending view through a small 32-bit register bus.

The enable mask has no read-modify-write register. Software sets bits through one write-one-to-set register and clears bits through a separate write-one-to-clear register, so two agents cannot race on a shared mask word. To acknowledge events, software writes the value it read from status back to the pending register. Only the bits written as one are cleared. An event that arrives while older events are being acknowledged is not lost.

Top module: `irq_feed_agg`

## Requirements
- R1: After a synchronous active-high reset, status, enable mask and read data are all zero and `irq_o` is low.
- R2: A one on `evt_i[k]` at a clock edge sets status bit k at that edge. The bit stays set until it is acknowledged. Bit 3 is the input-block DMA source, bit 2 the output-block DMA source, bit 1 the hash-input DMA source and bit 0 the public-key DMA source. The same bit order holds in every register.
- R3: A write to offset 0x04 sets every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R4: A write to offset 0x08 clears every enable bit whose write-data bit is 1. Enable bits whose write-data bit is 0 keep their value.
- R5: A read of offset 0x0C returns status AND enable in bits 3..0.
- R6: A write to offset 0x0C clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are left as they are.
- R7: When an event and an acknowledge of the same bit arrive in the same cycle, that status bit ends up set.
- R8: `irq_o` is high exactly when at least one bit of status AND enable is set. It follows register state with no extra delay.
- R9: A read of offset 0x00 returns the status bits. A read of offset 0x04 or 0x08 returns the current enable mask. Bits 31..4 of any read are zero.
- R10: A write to offset 0x00, or to any offset other than 0x04, 0x08 or 0x0C, changes no state. A read of any offset other than 0x00, 0x04, 0x08 or 0x0C returns zero.
- R11: Read data is registered. `bus_rdata` takes the value of the register read on the edge where `bus_rd_en` is high, and holds it while `bus_rd_en` is low. A read and a write in the same cycle return the state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 4 | Single-cycle DMA completion pulses, one bit per source |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets three corner cases.

- An event and an acknowledge of the same bit in the same cycle. A design that lets the clear win drops the event silently, and the interrupt never fires for it.
- Partial acknowledges and partial mask writes, where zero bits in the write data must leave state alone. A design that loads the write data instead of OR-ing or masking it wipes out unrelated sources.
- Writes to the status offset and to undefined or unaligned offsets, followed by read-back and a check of the interrupt line. A loose address decoder would alias these onto the mask or the acknowledge path.

Same-cycle read and write is also covered: a design that returns post-write data would show its mask change one cycle early.

// File: rtl/irq_feed_agg_pkg.sv
package irq_feed_agg_pkg;

    localparam int unsigned SRC_COUNT   = 4;
    localparam int unsigned BUS_ADDR_W  = 8;
    localparam int unsigned BUS_DATA_W  = 32;

    // Byte offsets of the register file
    localparam int unsigned OFS_STATUS  = 'h00;
    localparam int unsigned OFS_EN_SET  = 'h04;
    localparam int unsigned OFS_EN_CLR  = 'h08;
    localparam int unsigned OFS_PENDING = 'h0C;

    // Source bit positions, shared by all registers
    localparam int unsigned SRC_BIT_PKEY   = 0;
    localparam int unsigned SRC_BIT_HASHIN = 1;
    localparam int unsigned SRC_BIT_OUTBLK = 2;
    localparam int unsigned SRC_BIT_INBLK  = 3;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_PENDING,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        logic     rd;
        reg_sel_e sel;
    } bus_op_t;

    function automatic reg_sel_e decode_offset(input int unsigned ofs);
        reg_sel_e s;
        case (ofs)
            OFS_STATUS:  s = SEL_STATUS;
            OFS_EN_SET:  s = SEL_EN_SET;
            OFS_EN_CLR:  s = SEL_EN_CLR;
            OFS_PENDING: s = SEL_PENDING;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] ack,
    output logic [NUM_SRC-1:0] status
);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cell
        logic flag_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q <= 1'b0;
            end else if (evt[k]) begin
                // a fresh event outranks an acknowledge in the same cycle
                flag_q <= 1'b1;
            end else if (ack[k]) begin
                flag_q <= 1'b0;
            end
        end

        assign status[k] = flag_q;
    end

endmodule

// File: rtl/irq_en_mask.sv
module irq_en_mask #(
    parameter int unsigned NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_bits,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] enable
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] en_d;

    always_comb begin
        en_d = (en_q | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign enable = en_q;

endmodule

// File: rtl/irq_rd_port.sv
module irq_rd_port
    import irq_feed_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  bus_op_t            op,
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC-1:0] enable,
    output logic [DATA_W-1:0]  rdata
);

    logic [NUM_SRC-1:0] field;
    logic [DATA_W-1:0]  rdata_q;

    always_comb begin
        case (op.sel)
            SEL_STATUS:  field = status;
            SEL_EN_SET:  field = enable;
            SEL_EN_CLR:  field = enable;
            SEL_PENDING: field = status & enable;
            default:     field = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (op.rd) begin
            rdata_q <= DATA_W'(field);
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/irq_feed_agg.sv
module irq_feed_agg
    import irq_feed_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_COUNT,
    parameter int unsigned ADDR_W  = BUS_ADDR_W,
    parameter int unsigned DATA_W  = BUS_DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               bus_wr_en,
    input  logic               bus_rd_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_o
);

    localparam int unsigned SPARE_W = DATA_W - NUM_SRC;

    bus_op_t            op;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] ack_vec;
    logic [NUM_SRC-1:0] stat_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic               unused_spare;

    assign unused_spare = ^bus_wdata[DATA_W-1:DATA_W-SPARE_W];
    assign wbits        = bus_wdata[NUM_SRC-1:0];

    always_comb begin
        op.wr  = bus_wr_en;
        op.rd  = bus_rd_en;
        op.sel = decode_offset(int'(bus_addr));
    end

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        ack_vec = '0;
        if (op.wr) begin
            case (op.sel)
                SEL_EN_SET:  set_vec = wbits;
                SEL_EN_CLR:  clr_vec = wbits;
                SEL_PENDING: ack_vec = wbits;
                default:     ;
            endcase
        end
    end

    irq_src_bank #(.NUM_SRC(NUM_SRC)) u_src (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_i),
        .ack    (ack_vec),
        .status (stat_vec)
    );

    irq_en_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_vec),
        .clr_bits (clr_vec),
        .enable   (en_vec)
    );

    irq_rd_port #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .status (stat_vec),
        .enable (en_vec),
        .rdata  (bus_rdata)
    );

    assign irq_o = |(stat_vec & en_vec);

endmodule

// File: rtl/irq_feed_agg_chk.sv
module irq_feed_agg_chk
    import irq_feed_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC = 4,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned DATA_W  = 32
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_i,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SRC-1:0] wdata_lo,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] enable
);

    logic wr_set, wr_clr, wr_ack, wr_dead;
    logic [NUM_SRC-1:0] ack_bits;

    assign wr_set   = bus_wr_en && (int'(bus_addr) == OFS_EN_SET);
    assign wr_clr   = bus_wr_en && (int'(bus_addr) == OFS_EN_CLR);
    assign wr_ack   = bus_wr_en && (int'(bus_addr) == OFS_PENDING);
    assign wr_dead  = bus_wr_en && !wr_set && !wr_clr && !wr_ack;
    assign ack_bits = wr_ack ? wdata_lo : '0;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status == '0) && (enable == '0) && (bus_rdata == '0) && !irq_o);

    assert_event_sticks_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_i != '0) |=> ((status & $past(evt_i)) == $past(evt_i)));

    assert_enable_set_R3: assert property (@(posedge clk) disable iff (rst)
        wr_set |=> ((enable & $past(wdata_lo)) == $past(wdata_lo)));

    assert_enable_clear_R4: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> ((enable & $past(wdata_lo)) == '0));

    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
        wr_ack |=> ((status & $past(ack_bits & ~evt_i)) == '0));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && ((ack_bits & evt_i) != '0)) |=>
            ((status & $past(ack_bits & evt_i)) == $past(ack_bits & evt_i)));

    assert_dead_write_R10: assert property (@(posedge clk) disable iff (rst)
        wr_dead |=> $stable(enable) && ((status & $past(status)) == $past(status)));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_en |=> $stable(bus_rdata));

endmodule

bind irq_feed_agg irq_feed_agg_chk #(
    .NUM_SRC (NUM_SRC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .wdata_lo  (bus_wdata[NUM_SRC-1:0]),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .status    (stat_vec),
    .enable    (en_vec)
);

// File: tb/irq_feed_agg_tb.sv
`timescale 1ns/1ps
module irq_feed_agg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  evt_i = '0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    // reference state
    logic [3:0]  m_stat = '0;
    logic [3:0]  m_en   = '0;
    logic [31:0] m_rd   = '0;

    always #2.5 clk = ~clk;

    irq_feed_agg u_dut (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00:   return {28'd0, m_stat};
            8'h04:   return {28'd0, m_en};
            8'h08:   return {28'd0, m_en};
            8'h0C:   return {28'd0, m_stat & m_en};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock: drive now (just after a falling edge), compare at next falling edge
    task automatic step(input logic [3:0] ev, input bit wr, input bit rd,
                        input logic [7:0] a, input logic [31:0] d, input string tag);
        logic [3:0]  ack, setb, clrb;
        logic [31:0] rd_next;
        evt_i     = ev;
        bus_wr_en = wr;
        bus_rd_en = rd;
        bus_addr  = a;
        bus_wdata = d;
        ack  = (wr && a == 8'h0C) ? d[3:0] : 4'h0;
        setb = (wr && a == 8'h04) ? d[3:0] : 4'h0;
        clrb = (wr && a == 8'h08) ? d[3:0] : 4'h0;
        rd_next = rd ? m_read(a) : m_rd;
        @(posedge clk);
        #1;
        m_stat = (m_stat & ~ack) | ev;
        m_en   = (m_en | setb) & ~clrb;
        m_rd   = rd_next;
        @(negedge clk);
        check32(tag, "rdata", bus_rdata, m_rd);
        check32(tag, "irq", {31'd0, irq_o}, {31'd0, |(m_stat & m_en)});
        evt_i = '0; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    endtask

    task automatic idle(input string tag);
        step(4'h0, 1'b0, 1'b0, 8'h00, 32'h0, tag);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(4'h0, 1'b1, 1'b0, a, d, tag);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        step(4'h0, 1'b0, 1'b1, a, 32'h0, tag);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check32("R1", "rdata", bus_rdata, 32'h0);
        check32("R1", "irq", {31'd0, irq_o}, 32'h0);
        rd(8'h00, "R1"); rd(8'h04, "R1"); rd(8'h0C, "R1");

        // R2: each source latches, bit order 3=in-block..0=pkey
        for (int k = 0; k < 4; k++) begin
            step(4'(1 << k), 1'b0, 1'b0, 8'h00, 0, "R2");
            idle("R2");
            rd(8'h00, "R2");
            wr(8'h0C, 32'h0000000F, "R6");
            rd(8'h00, "R6");
        end
        // R8: nothing enabled, events pending -> no irq
        step(4'hA, 1'b0, 1'b0, 8'h00, 0, "R8");
        rd(8'h0C, "R5");
        // R3: partial set leaves others
        wr(8'h04, 32'hFFFF_FFF2, "R3");
        rd(8'h04, "R9");
        wr(8'h04, 32'h0000_0001, "R3");
        rd(8'h08, "R9");
        rd(8'h0C, "R5");
        // R4: partial clear
        wr(8'h08, 32'h0000_0002, "R4");
        rd(8'h04, "R4");
        rd(8'h0C, "R8");
        wr(8'h04, 32'h0000_000F, "R3");
        // R6: partial acknowledge leaves zero bits
        step(4'h5, 1'b0, 1'b0, 8'h00, 0, "R2");
        rd(8'h00, "R6");
        wr(8'h0C, 32'h0000_0003, "R6");
        rd(8'h00, "R6");
        // R7: event and ack collide on same bit
        step(4'h4, 1'b1, 1'b0, 8'h0C, 32'h0000_000C, "R7");
        rd(8'h00, "R7");
        wr(8'h0C, 32'h0000_000F, "R7");
        rd(8'h0C, "R8");
        // R10: writes to status and undefined offsets
        step(4'h9, 1'b0, 1'b0, 8'h00, 0, "R10");
        wr(8'h00, 32'h0000_000F, "R10");
        wr(8'h10, 32'h0000_000F, "R10");
        wr(8'h05, 32'h0000_000F, "R10");
        wr(8'h09, 32'h0000_000F, "R10");
        wr(8'h0D, 32'h0000_000F, "R10");
        wr(8'hFC, 32'hFFFF_FFFF, "R10");
        rd(8'h00, "R10");
        rd(8'h04, "R10");
        rd(8'h14, "R10");
        rd(8'h01, "R10");
        // R11: hold with no read, read+write same cycle returns old state
        idle("R11"); idle("R11");
        step(4'h0, 1'b1, 1'b1, 8'h08, 32'h0000_000F, "R11");
        rd(8'h04, "R11");
        idle("R11");

        // mixed traffic against the model
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            int pick;
            pick = $urandom_range(0, 6);
            case (pick)
                0: a = 8'h00; 1: a = 8'h04; 2: a = 8'h08; 3: a = 8'h0C;
                4: a = 8'h10; 5: a = 8'h02; default: a = 8'h0C;
            endcase
            step(4'($urandom_range(0, 15) & $urandom_range(0, 15)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 a, $urandom, "R2");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule